// File: doc/BRIEF.md
# Multicycle 16-bit Register Core

This block is a compact multicycle processor for a fixed-width 16-bit load/store instruction set. Every instruction passes through a fetch step, an instruction-register load step and an execute step. Loads add one further write-back step. The core holds a program counter, an instruction register, eight 16-bit general registers and a three-bit sign flag set. The supported work is register or immediate addition, bitwise AND, bitwise inversion, a load from a base register plus a signed offset, and a jump that copies a register into the program counter.

The core reaches memory through one port. A read is requested by raising `memRd` with an address on `memAddr`. The memory answers on `memRdata` in the following cycle. The core has no store instruction, so the write strobe and the write data stay low. Two debug outputs expose the program counter and the sign flags, which lets a system or a bench follow execution.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), the program counter is set to 0x3000 and the flags are set to zero (`dbgCc` = 3'b010). All eight registers are cleared. The first cycle after reset is a fetch from 0x3000.
- R2: A fetch drives `memAddr` with the program counter and raises `memRd`. It increments the program counter by one. The word on `memRdata` in the following cycle becomes the instruction. `memWr` is never raised and `memWdata` is always zero.
- R3: Opcode 0001 (bits [15:12]) adds. Bit 5 = 0 adds registers [8:6] and [2:0]. Bit 5 = 1 adds register [8:6] and the sign-extended immediate in [4:0]. The result goes to register [11:9].
- R4: Opcode 0101 writes to register [11:9] the bitwise AND of register [8:6] and either register [2:0] or the sign-extended immediate in [4:0]. Bit 5 selects between them in the same way as for addition.
- R5: Opcode 1001 writes the bitwise inverse of register [8:6] into register [11:9].
- R6: Opcode 0110 reads the memory word at register [8:6] plus the sign-extended offset in [5:0] and writes it to register [11:9]. The offset range is -32 to +31.
- R7: Opcode 1100 loads the program counter from register [8:6]. The next fetch uses that address, and the flags are left unchanged.
- R8: After each add, AND, invert or load, exactly one flag is set according to the sign of the written value. `dbgCc` bit 2 means negative, bit 1 means zero and bit 0 means positive.
- R9: Any other opcode behaves as a no-operation. Registers and flags are unchanged and execution continues at the next address.
- R10: Add, AND, invert, jump and no-operation each take 3 cycles from fetch to fetch. A load takes 4 cycles, and its data read comes 2 cycles after its fetch. A cycle with `memRd` high is always followed by one with `memRd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 16 | Memory address for fetch or load |
| memWdata | output | 16 | Memory write data, always zero |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe, always low |
| memRdata | input | 16 | Read data, valid the cycle after `memRd` |
| dbgPc | output | 16 | Current program counter |
| dbgCc | output | 3 | Flags {negative, zero, positive} |

## Verification
The bench builds the core with its default parameters: a 16-bit word and a reset address of 0x3000. With these values, real jump targets in the program area are within reach, and loads can wrap across the top half of the address space. The bench writes a program whose loads use registers as bases, so each register value becomes visible on `memAddr`. The program covers the largest positive and negative offsets and immediates, a no-operation opcode and a jump. The scoreboard compares every read address, the flags seen at each fetch, and the cycle gap since the previous read.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int REG_COUNT = 8;
  localparam int REG_AW = $clog2(REG_COUNT);

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_JMP = 4'b1100;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_LOADIR,
    ST_EXEC,
    ST_MEMWB
  } coreState_t;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_AND,
    ALU_NOT,
    ALU_PASS
  } aluOp_t;

  typedef struct packed {
    logic irLoad;
    logic pcInc;
    logic pcJump;
    logic regWrite;
    logic wbFromMem;
    logic ccLoad;
    logic dataAddr;
    logic memRd;
  } ctlStrobes_t;
endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  aluOp_t            op,
  input  logic [XLEN-1:0]   opA,
  input  logic [XLEN-1:0]   opB,
  output logic [XLEN-1:0]   result
);
  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_AND: result = opA & opB;
      ALU_NOT: result = ~opA;
      default: result = opA;
    endcase
  end
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  opcode,
  output ctlStrobes_t ctl
);
  coreState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  always_comb begin
    ctl = '0;
    stateNext = ST_FETCH;
    unique case (state)
      ST_FETCH: begin
        ctl.memRd = 1'b1;
        ctl.pcInc = 1'b1;
        stateNext = ST_LOADIR;
      end
      ST_LOADIR: begin
        ctl.irLoad = 1'b1;
        stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (opcode)
          OPC_ADD, OPC_AND, OPC_NOT: begin
            ctl.regWrite = 1'b1;
            ctl.ccLoad = 1'b1;
          end
          OPC_LDR: begin
            ctl.dataAddr = 1'b1;
            ctl.memRd = 1'b1;
            stateNext = ST_MEMWB;
          end
          OPC_JMP: ctl.pcJump = 1'b1;
          default: ;
        endcase
      end
      ST_MEMWB: begin
        ctl.regWrite = 1'b1;
        ctl.wbFromMem = 1'b1;
        ctl.ccLoad = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc16_dpath.sv
module mc16_dpath
  import mc16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       ctl,
  input  logic [XLEN-1:0]   memRdata,
  output logic [3:0]        opcode,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   dbgPc,
  output logic [2:0]        dbgCc
);
  logic [XLEN-1:0] pcReg, irReg;
  logic [2:0] ccReg;
  logic [XLEN-1:0] gpr [REG_COUNT];

  logic [REG_AW-1:0] dstIdx, srcAIdx, srcBIdx;
  logic [XLEN-1:0] srcA, srcB, immExt, offExt, ldAddr, aluOut, wbVal;
  aluOp_t aluOp;

  assign opcode  = irReg[15:12];
  assign dstIdx  = irReg[11:9];
  assign srcAIdx = irReg[8:6];
  assign srcBIdx = irReg[2:0];
  assign immExt  = {{(XLEN-5){irReg[4]}}, irReg[4:0]};
  assign offExt  = {{(XLEN-6){irReg[5]}}, irReg[5:0]};

  assign srcA   = gpr[srcAIdx];
  assign srcB   = irReg[5] ? immExt : gpr[srcBIdx];
  assign ldAddr = srcA + offExt;

  always_comb begin
    unique case (opcode)
      OPC_ADD: aluOp = ALU_ADD;
      OPC_AND: aluOp = ALU_AND;
      OPC_NOT: aluOp = ALU_NOT;
      default: aluOp = ALU_PASS;
    endcase
  end

  mc16_alu #(.XLEN(XLEN)) alu_i (
    .op(aluOp), .opA(srcA), .opB(srcB), .result(aluOut)
  );

  assign wbVal = ctl.wbFromMem ? memRdata : aluOut;

  generate
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_gpr
      always_ff @(posedge clk) begin
        if (rst) gpr[g] <= '0;
        else if (ctl.regWrite && dstIdx == REG_AW'(g)) gpr[g] <= wbVal;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= RESET_PC;
      irReg <= '0;
      ccReg <= 3'b010;
    end else begin
      if (ctl.pcJump)      pcReg <= srcA;
      else if (ctl.pcInc)  pcReg <= pcReg + 1'b1;
      if (ctl.irLoad)      irReg <= memRdata;
      if (ctl.ccLoad) begin
        if (wbVal[XLEN-1])     ccReg <= 3'b100;
        else if (wbVal == '0)  ccReg <= 3'b010;
        else                   ccReg <= 3'b001;
      end
    end
  end

  assign memAddr = ctl.dataAddr ? ldAddr : pcReg;
  assign dbgPc = pcReg;
  assign dbgCc = ccReg;
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic            memRd,
  output logic            memWr,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] dbgPc,
  output logic [2:0]      dbgCc
);
  ctlStrobes_t ctl;
  logic [3:0] opcode;

  mc16_ctrl ctrl_i (
    .clk(clk), .rst(rst), .opcode(opcode), .ctl(ctl)
  );

  mc16_dpath #(.XLEN(XLEN), .RESET_PC(RESET_PC)) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata),
    .opcode(opcode), .memAddr(memAddr), .dbgPc(dbgPc), .dbgCc(dbgCc)
  );

  assign memRd = ctl.memRd;
  assign memWr = 1'b0;
  assign memWdata = '0;
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
  import mc16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
  input logic            clk,
  input logic            rst,
  input logic            memRd,
  input logic            memWr,
  input logic [XLEN-1:0] dbgPc,
  input logic [2:0]      dbgCc,
  input ctlStrobes_t     ctl
);
  // R1: one cycle after reset is sampled high, PC and flags hold their reset values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dbgPc == RESET_PC && dbgCc == 3'b010));

  // R2: the write strobe never rises
  a_r2_no_write: assert property (@(posedge clk) disable iff (rst) !memWr);

  // R2: a fetch advances the PC by exactly one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc |=> dbgPc == $past(dbgPc) + 1'b1);

  // R7: a jump leaves the flags untouched
  a_r7_jump_keeps_cc: assert property (@(posedge clk) disable iff (rst)
    ctl.pcJump |=> $stable(dbgCc));

  // R8: exactly one flag is set at all times
  a_r8_cc_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(dbgCc) == 1);

  // R10: a read cycle is never followed directly by another read
  a_r10_read_gap: assert property (@(posedge clk) disable iff (rst)
    memRd |=> !memRd);
endmodule

bind mc16_core mc16_core_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) chk_i (
  .clk(clk), .rst(rst), .memRd(memRd), .memWr(memWr),
  .dbgPc(dbgPc), .dbgCc(dbgCc), .ctl(ctl)
);

// File: tb/mc16_core_tb_top.sv
module mc16_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] memAddr, memWdata, dbgPc;
  logic [15:0] memRdata = '0;
  logic memRd, memWr;
  logic [2:0] dbgCc;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lastRdCyc = -1;
  bit wrSeen = 0;

  typedef struct {
    logic [15:0] addr;
    bit          isFetch;
    logic [2:0]  cc;
    int          gap;
    string       tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  logic [15:0] prog [0:255];
  logic [15:0] dmem [0:31];

  always #4 clk = ~clk;  // 125 MHz

  mc16_core dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRd(memRd), .memWr(memWr), .memRdata(memRdata),
    .dbgPc(dbgPc), .dbgCc(dbgCc)
  );

  function automatic logic [15:0] readWord(logic [15:0] a);
    if (a[15:8] == 8'h30) return prog[a[7:0]];
    if (a < 16'd32)       return dmem[a[4:0]];
    return ~a;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memRd) memRdata <= readWord(memAddr);
  end

  function automatic logic [15:0] encR(logic [3:0] op, int d, int a, int b);
    return {op, d[2:0], a[2:0], 3'b000, b[2:0]};
  endfunction
  function automatic logic [15:0] encI(logic [3:0] op, int d, int a, int imm);
    return {op, d[2:0], a[2:0], 1'b1, imm[4:0]};
  endfunction
  function automatic logic [15:0] encNot(int d, int a);
    return {4'b1001, d[2:0], a[2:0], 6'h3F};
  endfunction
  function automatic logic [15:0] encLd(int d, int b, int off);
    return {4'b0110, d[2:0], b[2:0], off[5:0]};
  endfunction
  function automatic logic [15:0] encJmp(int b);
    return {4'b1100, 3'b000, b[2:0], 6'b0};
  endfunction

  task automatic pushItem(logic [15:0] a, bit f, logic [2:0] c, int g, string t);
    sbItem_t it;
    it.addr = a; it.isFetch = f; it.cc = c; it.gap = g; it.tag = t;
    sbQ.push_back(it);
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one item per read strobe and compares address, flags and timing
  always @(negedge clk) begin
    if (!rst) begin
      if (memWr) wrSeen = 1;
      if (memRd && sbQ.size() > 0) begin
        sbItem_t it;
        int gap;
        it = sbQ.pop_front();
        gap = (lastRdCyc < 0) ? 0 : cyc - lastRdCyc;
        lastRdCyc = cyc;
        check(memAddr == it.addr, it.tag, "address", {16'h0, memAddr}, {16'h0, it.addr});
        if (it.isFetch)
          check(dbgCc == it.cc, it.tag, "flags", {29'h0, dbgCc}, {29'h0, it.cc});
        if (it.gap > 0)
          check(gap == it.gap, "R10", "cycle gap", gap, it.gap);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    for (int i = 0; i < 32; i++) dmem[i] = 16'(i);
    dmem[5] = 16'h1234;
    dmem[6] = 16'h8001;
    dmem[7] = 16'h3020;

    prog[8'h00] = encLd(1, 0, 5);            // R1=1234
    prog[8'h01] = encLd(2, 0, 6);            // R2=8001
    prog[8'h02] = encR(4'b0001, 3, 1, 2);    // R3=9235
    prog[8'h03] = encI(4'b0001, 4, 1, -1);   // R4=1233
    prog[8'h04] = encI(4'b0101, 5, 1, 0);    // R5=0
    prog[8'h05] = encR(4'b0101, 6, 3, 2);    // R6=8001
    prog[8'h06] = encNot(7, 1);              // R7=EDCB
    prog[8'h07] = encLd(5, 4, 0);            // addr 1233
    prog[8'h08] = encLd(5, 3, -32);          // addr 9215
    prog[8'h09] = encLd(6, 7, 31);           // addr EDEA, R6=1215
    prog[8'h0A] = encI(4'b0001, 0, 0, 15);   // R0=000F
    prog[8'h0B] = encI(4'b0001, 0, 0, -16);  // R0=FFFF
    prog[8'h0C] = encI(4'b0001, 0, 0, 1);    // R0=0
    prog[8'h0D] = 16'hF025;                  // unimplemented
    prog[8'h0E] = encLd(1, 0, 7);            // R1=3020
    prog[8'h0F] = encJmp(1);
    prog[8'h20] = encI(4'b0101, 2, 2, 0);    // R2=0
    prog[8'h21] = encLd(3, 3, 0);            // addr 9235
    prog[8'h22] = encLd(5, 6, 0);            // addr 1215, R5=EDEA

    pushItem(16'h3000, 1, 3'b010, 0, "R1");
    pushItem(16'h0005, 0, 3'b000, 2, "R6");
    pushItem(16'h3001, 1, 3'b001, 2, "R8");
    pushItem(16'h0006, 0, 3'b000, 2, "R6");
    pushItem(16'h3002, 1, 3'b100, 2, "R8");
    pushItem(16'h3003, 1, 3'b100, 3, "R3");
    pushItem(16'h3004, 1, 3'b001, 3, "R3");
    pushItem(16'h3005, 1, 3'b010, 3, "R4");
    pushItem(16'h3006, 1, 3'b100, 3, "R4");
    pushItem(16'h3007, 1, 3'b100, 3, "R5");
    pushItem(16'h1233, 0, 3'b000, 2, "R3");
    pushItem(16'h3008, 1, 3'b100, 2, "R6");
    pushItem(16'h9215, 0, 3'b000, 2, "R6");
    pushItem(16'h3009, 1, 3'b001, 2, "R6");
    pushItem(16'hEDEA, 0, 3'b000, 2, "R5");
    pushItem(16'h300A, 1, 3'b001, 2, "R6");
    pushItem(16'h300B, 1, 3'b001, 3, "R3");
    pushItem(16'h300C, 1, 3'b100, 3, "R3");
    pushItem(16'h300D, 1, 3'b010, 3, "R8");
    pushItem(16'h300E, 1, 3'b010, 3, "R9");
    pushItem(16'h0007, 0, 3'b000, 2, "R9");
    pushItem(16'h300F, 1, 3'b001, 2, "R2");
    pushItem(16'h3020, 1, 3'b001, 3, "R7");
    pushItem(16'h3021, 1, 3'b010, 3, "R4");
    pushItem(16'h9235, 0, 3'b000, 2, "R3");
    pushItem(16'h3022, 1, 3'b001, 2, "R6");
    pushItem(16'h1215, 0, 3'b000, 2, "R6");
    pushItem(16'h3023, 1, 3'b100, 2, "R6");

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // reset state, sampled before the first post-reset edge
    check(dbgPc == 16'h3000, "R1", "reset pc", {16'h0, dbgPc}, 32'h3000);
    check(dbgCc == 3'b010, "R1", "reset flags", {29'h0, dbgCc}, 32'h2);

    begin
      int wd = 0;
      while (sbQ.size() > 0 && wd < 2000) begin
        @(negedge clk);
        wd++;
      end
      @(negedge clk);
      if (sbQ.size() > 0) begin
        checks++;
        fails++;
        $display("FAIL R10 watchdog: actual %0d pending expected 0", sbQ.size());
      end
    end
    check(!wrSeen, "R2", "write strobe seen", {31'h0, wrSeen}, 32'h0);
    check(memWdata == 16'h0, "R2", "write data", {16'h0, memWdata}, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule